// File: doc/BRIEF.md
# Graphics Port Arbiter Status Decoder and Read-Return Tracker

This block sits beside the request-enqueue logic of a pipelined graphics-port bus master. Each clock it looks at the arbiter's 3-bit status code together with the active-low grant line and names the cycle: a low- or high-priority read return, a request from the arbiter for low- or high-priority write data, permission to start a new bus operation, or nothing. The status code is decoded only while the grant is asserted. In every other cycle it is ignored.

Read requests that the enqueue logic has posted are kept in two separate in-order queues, one for each priority. Each entry holds the request's length in 8-byte beats. Returned beats are counted against the oldest entry of their own class. When that entry's last beat arrives, a completion pulse is sent back to the enqueue logic. The block also counts the low-priority beats that sit in local receive storage and drives the active-low read-buffer-full line, which holds off new low-priority returns. High-priority returns are never held off. Any return that matches no outstanding request, and any new low-priority return that starts while the buffer-full line is asserted, sets a sticky protocol-error flag.

Top module: `agp_rtn_tracker`

## Requirements
- R1: While `gnt_n` is 0, the status code `arb_st` is decoded into `cyc_class`, one clock after it is sampled. The mapping is 000→1 (low read return), 001→2 (high read return), 010→3 (low write data), 011→4 (high write data) and 111→5 (start).
- R2: While `gnt_n` is 1, `cyc_class` is 0 whatever `arb_st` holds. No beat is counted, no completion pulse is raised and no error is flagged.
- R3: The reserved codes 100, 101 and 110 give `cyc_class` 0 even while the grant is asserted.
- R4: An `enq_valid` pulse pushes `enq_len` (beats minus one, LEN_W bits) into the high queue when `enq_hi` is 1 and into the low queue otherwise. Each queue holds DEPTH (4) requests, and its full flag is set while it holds DEPTH. A push into a full queue is dropped.
- R5: Each return beat of a class is counted against the oldest outstanding request of that class. The class's done output pulses for one cycle, one clock after the beat that completes `enq_len`+1 beats, and that request then leaves its queue.
- R6: The two classes are tracked independently. Beats of different priority may arrive on consecutive clocks in any order, and requests complete in order within each class.
- R7: A return beat whose class queue is empty sets `proto_err` one clock later. The flag stays set until reset.
- R8: The count of held low-priority beats rises by one for each low-priority return beat and falls by one for each `lp_drain` while it is non-zero. It saturates at SPACE (16). `rbf_n` is 0 exactly while SPACE minus that count is below 2^LEN_W (8).
- R9: High-priority return beats leave the held count and `rbf_n` unchanged.
- R10: A low-priority beat that starts a new request (its beat count is zero) while `rbf_n` is 0 sets `proto_err`. Beats that continue a request already in progress are accepted without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| gnt_n | input | 1 | Arbiter grant, active low |
| arb_st | input | 3 | Arbiter status code |
| enq_valid | input | 1 | A read request has just been enqueued |
| enq_hi | input | 1 | The enqueued request is high priority |
| enq_len | input | LEN_W | Enqueued request length in beats, minus one |
| lp_drain | input | 1 | One held low-priority beat was consumed downstream |
| cyc_class | output | 3 | Registered cycle class, encoded as in R1 |
| lp_done | output | 1 | Oldest low-priority request completed |
| hp_done | output | 1 | Oldest high-priority request completed |
| lp_full | output | 1 | Low-priority queue full |
| hp_full | output | 1 | High-priority queue full |
| rbf_n | output | 1 | Read buffer full, active low |
| proto_err | output | 1 | Sticky protocol error |

## Verification
A queue pointer or beat counter that goes wrong does not stay hidden for long. The next return of that class either raises its done pulse one clock early or late, lands on an empty queue and raises `proto_err`, or leaves `lp_full`/`hp_full` wrong after the next push. A held-count error moves the `rbf_n` edge off the beat where the free space crosses eight. The bench compares every port on every clock against a model built from the requirements, so any of these differences shows up on the first clock where it reaches an output.

// File: rtl/agp_trk_pkg.sv
package agp_trk_pkg;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_LP_RD = 3'd1,
        CLS_HP_RD = 3'd2,
        CLS_LP_WR = 3'd3,
        CLS_HP_WR = 3'd4,
        CLS_START = 3'd5
    } cyc_cls_e;

    localparam int NCLASS = 2;
    localparam int PRI_LO = 0;
    localparam int PRI_HI = 1;

    // Grant is active low; the status code carries meaning only under grant.
    function automatic cyc_cls_e classify(input logic gnt_n, input logic [2:0] code);
        cyc_cls_e c;
        c = CLS_NONE;
        if (!gnt_n) begin
            case (code)
                3'b000:  c = CLS_LP_RD;
                3'b001:  c = CLS_HP_RD;
                3'b010:  c = CLS_LP_WR;
                3'b011:  c = CLS_HP_WR;
                3'b111:  c = CLS_START;
                default: c = CLS_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/agp_st_decode.sv
module agp_st_decode
    import agp_trk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  gnt_n,
    input  logic [2:0]            arb_st,
    output cyc_cls_e              cls_q,
    output logic [NCLASS-1:0]     beat_v
);

    cyc_cls_e cls_now;

    always_comb begin
        cls_now        = classify(gnt_n, arb_st);
        beat_v         = '0;
        beat_v[PRI_LO] = (cls_now == CLS_LP_RD);
        beat_v[PRI_HI] = (cls_now == CLS_HP_RD);
    end

    always_ff @(posedge clk) begin
        if (rst) cls_q <= CLS_NONE;
        else     cls_q <= cls_now;
    end

    // R2
    nogrant_none_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_n |=> (cls_q == CLS_NONE));

    // R3
    reserved_none_chk: assert property (@(posedge clk) disable iff (rst)
        (!gnt_n && (arb_st inside {3'b100, 3'b101, 3'b110})) |=> (cls_q == CLS_NONE));

endmodule

// File: rtl/agp_class_track.sv
module agp_class_track #(
    parameter int DEPTH = 4,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic             beat,
    output logic             done,
    output logic             full,
    output logic             in_burst,
    output logic             err
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic [LEN_W-1:0] beat_cnt;
    logic             empty, last, pop, push_ok;

    always_comb begin
        empty    = (count == '0);
        full     = (count == FULL_CNT);
        last     = !empty && (beat_cnt == len_mem[rd_ptr]);
        pop      = beat && last;
        push_ok  = push && !full;
        in_burst = (beat_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (push_ok) len_mem[wr_ptr] <= push_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            beat_cnt <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)     rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (beat && !empty) beat_cnt <= last ? '0 : beat_cnt + 1'b1;
            done <= pop;
            err  <= err | (beat && empty);
        end
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R5
    done_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(beat));

    // R5
    beat_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (beat && !empty && !last) |=> (beat_cnt == $past(beat_cnt) + 1'b1));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !beat) |=> (count == $past(count)));

endmodule

// File: rtl/agp_rbf_credit.sv
module agp_rbf_credit #(
    parameter int SPACE     = 16,
    parameter int MAX_BEATS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_beat,
    input  logic lp_first,
    input  logic drain,
    output logic rbf_n,
    output logic viol
);

    localparam int HW = $clog2(SPACE + 1);
    localparam logic [HW-1:0] SPACE_C = HW'(SPACE);
    localparam logic [HW-1:0] MAX_C   = HW'(MAX_BEATS);

    logic [HW-1:0] held, held_nxt, free;

    always_comb begin
        free     = SPACE_C - held;
        rbf_n    = !(free < MAX_C);
        viol     = lp_beat && lp_first && !rbf_n;
        held_nxt = held;
        if (drain && held != '0)          held_nxt = held_nxt - 1'b1;
        if (lp_beat && held_nxt != SPACE_C) held_nxt = held_nxt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= held_nxt;
    end

    // R8
    held_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_beat && !drain && held < SPACE_C) |=> (held == $past(held) + 1'b1));

    // R8
    held_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!lp_beat && drain && held != '0) |=> (held == $past(held) - 1'b1));

endmodule

// File: rtl/agp_rtn_tracker.sv
module agp_rtn_tracker
    import agp_trk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 3,
    parameter int SPACE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gnt_n,
    input  logic [2:0]       arb_st,
    input  logic             enq_valid,
    input  logic             enq_hi,
    input  logic [LEN_W-1:0] enq_len,
    input  logic             lp_drain,
    output logic [2:0]       cyc_class,
    output logic             lp_done,
    output logic             hp_done,
    output logic             lp_full,
    output logic             hp_full,
    output logic             rbf_n,
    output logic             proto_err
);

    localparam int MAX_BEATS = 2 ** LEN_W;

    cyc_cls_e          cls_q;
    logic [NCLASS-1:0] beat_v, done_v, full_v, burst_v, err_v;
    logic              viol, viol_err;

    agp_st_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .gnt_n  (gnt_n),
        .arb_st (arb_st),
        .cls_q  (cls_q),
        .beat_v (beat_v)
    );

    for (genvar p = 0; p < NCLASS; p++) begin : g_cls
        logic push_p;
        assign push_p = enq_valid && (enq_hi == (p == PRI_HI));

        agp_class_track #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_trk (
            .clk      (clk),
            .rst      (rst),
            .push     (push_p),
            .push_len (enq_len),
            .beat     (beat_v[p]),
            .done     (done_v[p]),
            .full     (full_v[p]),
            .in_burst (burst_v[p]),
            .err      (err_v[p])
        );

        // R5
        done_restart_chk: assert property (@(posedge clk) disable iff (rst)
            done_v[p] |-> !burst_v[p]);
    end

    agp_rbf_credit #(.SPACE(SPACE), .MAX_BEATS(MAX_BEATS)) u_rbf (
        .clk      (clk),
        .rst      (rst),
        .lp_beat  (beat_v[PRI_LO]),
        .lp_first (!burst_v[PRI_LO]),
        .drain    (lp_drain),
        .rbf_n    (rbf_n),
        .viol     (viol)
    );

    always_ff @(posedge clk) begin
        if (rst) viol_err <= 1'b0;
        else     viol_err <= viol_err | viol;
    end

    assign cyc_class = cls_q;
    assign lp_done   = done_v[PRI_LO];
    assign hp_done   = done_v[PRI_HI];
    assign lp_full   = full_v[PRI_LO];
    assign hp_full   = full_v[PRI_HI];
    assign proto_err = viol_err | (|err_v);

    // R9
    hp_keeps_rbf_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_v[PRI_HI] && !lp_drain) |=> $stable(rbf_n));

    // R10
    viol_flags_chk: assert property (@(posedge clk) disable iff (rst)
        viol |=> proto_err);

endmodule

// File: tb/test_agp_rtn_tracker.sv
`timescale 1ns/1ps
module test_agp_rtn_tracker;

    localparam int LEN_W = 3;
    localparam int DEPTH = 4;
    localparam int SPACE = 16;
    localparam int MAXB  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt_n = 1'b1;
    logic [2:0] arb_st = 3'b0;
    logic enq_valid = 1'b0, enq_hi = 1'b0, lp_drain = 1'b0;
    logic [LEN_W-1:0] enq_len = '0;
    logic [2:0] cyc_class;
    logic lp_done, hp_done, lp_full, hp_full, rbf_n, proto_err;

    always #2.5 clk = ~clk;

    agp_rtn_tracker #(.DEPTH(DEPTH), .LEN_W(LEN_W), .SPACE(SPACE)) i_agp_rtn_tracker (
        .clk(clk), .rst(rst), .gnt_n(gnt_n), .arb_st(arb_st),
        .enq_valid(enq_valid), .enq_hi(enq_hi), .enq_len(enq_len), .lp_drain(lp_drain),
        .cyc_class(cyc_class), .lp_done(lp_done), .hp_done(hp_done),
        .lp_full(lp_full), .hp_full(hp_full), .rbf_n(rbf_n), .proto_err(proto_err)
    );

    typedef struct {
        int    due;
        int    cls;
        bit    ld, hd, lf, hf, rbfn, er;
        string tag;
    } exp_t;

    exp_t  eq[$];
    int    total = 0, bad = 0, cyc = 0;
    bit    finished = 0;

    int    lq[$], hq[$];
    int    lcnt, hcnt, held;
    bit    merr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string fld, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, fld, act, exp, cyc);
        end
    endtask

    // monitor: pops expectations that fall due on this cycle
    always @(negedge clk) begin
        while (eq.size() > 0 && eq[0].due == cyc) begin
            exp_t e;
            e = eq.pop_front();
            chk(e.tag, "cyc_class", int'(cyc_class), e.cls);
            chk(e.tag, "lp_done",   int'(lp_done),   int'(e.ld));
            chk(e.tag, "hp_done",   int'(hp_done),   int'(e.hd));
            chk(e.tag, "lp_full",   int'(lp_full),   int'(e.lf));
            chk(e.tag, "hp_full",   int'(hp_full),   int'(e.hf));
            chk(e.tag, "rbf_n",     int'(rbf_n),     int'(e.rbfn));
            chk(e.tag, "proto_err", int'(proto_err), int'(e.er));
        end
    end

    function automatic bit rbf_of(input int h);
        return !((SPACE - h) < MAXB);
    endfunction

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input bit gn, input int st, input bit ev, input bit eh,
                        input int el, input bit dr, input string tag);
        exp_t e;
        int   cls;
        bit   lb, hb, lfull0, hfull0, rbf0;
        @(negedge clk);
        gnt_n = gn; arb_st = st[2:0]; enq_valid = ev; enq_hi = eh;
        enq_len = el[LEN_W-1:0]; lp_drain = dr;
        cls = 0;
        if (!gn) case (st)
            0: cls = 1; 1: cls = 2; 2: cls = 3; 3: cls = 4; 7: cls = 5;
            default: cls = 0;
        endcase
        lb = (cls == 1); hb = (cls == 2);
        lfull0 = (lq.size() == DEPTH); hfull0 = (hq.size() == DEPTH);
        rbf0 = rbf_of(held);
        e.ld = 0; e.hd = 0;
        if (lb) begin
            if (lq.size() == 0) merr = 1;
            else begin
                if (lcnt == 0 && !rbf0) merr = 1;
                if (lcnt == lq[0]) begin void'(lq.pop_front()); lcnt = 0; e.ld = 1; end
                else lcnt++;
            end
        end
        if (hb) begin
            if (hq.size() == 0) merr = 1;
            else if (hcnt == hq[0]) begin void'(hq.pop_front()); hcnt = 0; e.hd = 1; end
            else hcnt++;
        end
        if (ev) begin
            if (eh) begin if (!hfull0) hq.push_back(el); end
            else    begin if (!lfull0) lq.push_back(el); end
        end
        if (dr && held > 0) held--;
        if (lb && held < SPACE) held++;
        e.due = cyc + 1; e.cls = cls;
        e.lf = (lq.size() == DEPTH); e.hf = (hq.size() == DEPTH);
        e.rbfn = rbf_of(held); e.er = merr; e.tag = tag;
        eq.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        repeat (3) @(negedge clk);
        rst = 1; gnt_n = 1; arb_st = 0; enq_valid = 0; enq_hi = 0; enq_len = '0; lp_drain = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        lq.delete(); hq.delete(); lcnt = 0; hcnt = 0; held = 0; merr = 0; eq.delete();
        chk("reset", "cyc_class", int'(cyc_class), 0);
        chk("reset", "done", int'(lp_done | hp_done), 0);
        chk("reset", "full", int'(lp_full | hp_full), 0);
        chk("reset", "rbf_n", int'(rbf_n), 1);
        chk("reset", "proto_err", int'(proto_err), 0);
    endtask

    initial begin
        #100000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 write and start codes, R3 reserved codes
        step(0, 2, 0, 0, 0, 0, "R1");
        step(0, 3, 0, 0, 0, 0, "R1");
        step(0, 7, 0, 0, 0, 0, "R1");
        step(0, 4, 0, 0, 0, 0, "R3");
        step(0, 5, 0, 0, 0, 0, "R3");
        step(0, 6, 0, 0, 0, 0, "R3");
        // R4 one request per class, R2 status ignored without grant
        step(1, 0, 1, 0, 0, 0, "R4");
        step(1, 0, 1, 1, 0, 0, "R4");
        step(1, 0, 0, 0, 0, 0, "R2");
        step(1, 1, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 1, "R1");
        step(0, 1, 0, 0, 0, 0, "R1");
        // R5 / R6 interleaved priorities on consecutive clocks
        step(1, 0, 1, 0, 3, 0, "R5");
        step(1, 0, 1, 1, 1, 0, "R6");
        step(0, 0, 0, 0, 0, 1, "R6");
        step(0, 1, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 0, 1, "R6");
        step(0, 1, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 0, 1, "R5");
        idle("R5");
        // R4 fill low queue, drop the extra push, high queue still accepts
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0, 0, "R4");
        step(1, 0, 1, 0, 0, 0, "R4");
        step(1, 0, 1, 1, 0, 0, "R4");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, "R4");
        step(0, 1, 0, 0, 0, 1, "R4");
        idle("R4");
        // R8 / R9 / R10 buffer-full threshold
        step(1, 0, 1, 0, 7, 0, "R8");
        step(1, 0, 1, 0, 7, 0, "R8");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 1, 1, 2, 0, "R9");
        step(0, 1, 0, 0, 0, 0, "R9");
        step(0, 1, 0, 0, 0, 0, "R9");
        step(0, 1, 0, 0, 0, 0, "R9");
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 0, "R10");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 1, "R8");
        step(1, 0, 1, 0, 1, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        step(1, 0, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, "R10");
        idle("R7");
        idle("R7");
        // R7 return to an empty queue
        do_reset();
        idle("R7");
        step(0, 1, 0, 0, 0, 0, "R7");
        idle("R7");
        step(1, 0, 1, 0, 0, 1, "R7");
        idle("R7");
        step(0, 0, 0, 0, 0, 1, "R7");
        idle("R7");
        repeat (3) @(negedge clk);
        if (eq.size() != 0) chk("flush", "pending", eq.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule